// File: doc/BRIEF.md
# Ping-Pong Buffer Descriptor Indexer

This block sits beside the transaction engine of a 16-endpoint USB device controller. It keeps one even/odd toggle for every endpoint and direction, and it turns an endpoint and direction into the number and byte address of the buffer descriptor that covers it. Four buffering modes set which endpoint directions own an even/odd pair of descriptors and which own a single one. The mode therefore changes how the descriptor table is numbered.

Completion pulses from the transaction engine advance the toggles of double-buffered endpoint directions. Each accepted completion is also recorded in a small status record, which holds the endpoint, the direction and the even/odd half that the completion used. Lookups are combinational and have no handshake. Firmware can clear every toggle back to Even with one pulse. Dropping the module enable does the same and holds the toggles there.

Top module: `ppbd_indexer`

## Requirements
- R1: After reset `stat_valid` is 0 and every toggle is Even. While `enable` is 0 the toggles are held Even, and completion pulses leave the status outputs unchanged.
- R2: With `pp_mode`=00 (no pairs), the descriptor index of endpoint e and direction d is 2e+d. Direction 0 is OUT and 1 is IN.
- R3: With `pp_mode`=01, only endpoint 0 OUT has a pair, at indices 0 (even) and 1 (odd). Every other endpoint direction has index 2e+d+1, so endpoint 15 IN lands at 32.
- R4: With `pp_mode`=10 (pairs everywhere), the index is 4e+2d+p, where p is the current toggle of that endpoint direction (1 = Odd).
- R5: With `pp_mode`=11, endpoint 0 OUT is at 0 and endpoint 0 IN is at 1, both single. Endpoints 1 to 15 use 4e+2d+p-2, so endpoint 15 IN odd lands at 61.
- R6: `look_addr` equals 0x400 + 4 × `look_idx` for every valid lookup.
- R7: A completion (`xfer_done`=1 with `enable`=1) on a double-buffered endpoint direction flips that direction's toggle from the next cycle on. All other toggles stay as they were.
- R8: A single-buffered endpoint direction always reports Even on `look_odd` and `stat_odd`. Completions on it leave every toggle unchanged.
- R9: One cycle after an accepted completion, `stat_valid`=1, and `stat_ep`, `stat_dir` and `stat_odd` hold the endpoint, the direction and the toggle value in use before that completion.
- R10: A `ptr_clear` pulse returns every toggle to Even. When it coincides with a completion, the clear wins, and the status still records the completion.
- R11: A lookup with `look_ep` above 15 sets `look_invalid`=1 and drives `look_idx`, `look_addr` and `look_odd` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pp_mode | input | 2 | Buffering mode: 00 none, 01 EP0 OUT only, 10 all, 11 all but EP0 |
| enable | input | 1 | Module enable; low holds toggles Even and ignores completions |
| ptr_clear | input | 1 | Pulse that forces every toggle to Even |
| xfer_done | input | 1 | Transaction-complete pulse |
| xfer_ep | input | 4 | Endpoint of the completed transaction |
| xfer_dir | input | 1 | Direction of the completed transaction (0 OUT, 1 IN) |
| look_ep | input | 5 | Endpoint to look up (values above 15 are invalid) |
| look_dir | input | 1 | Direction to look up |
| look_idx | output | 6 | Descriptor index for the lookup |
| look_addr | output | 12 | Descriptor byte address for the lookup |
| look_odd | output | 1 | Even/odd half the lookup resolved to (1 = Odd) |
| look_invalid | output | 1 | Lookup endpoint out of range |
| stat_valid | output | 1 | A completion has been recorded |
| stat_ep | output | 4 | Endpoint of the last recorded completion |
| stat_dir | output | 1 | Direction of the last recorded completion |
| stat_odd | output | 1 | Even/odd half used by the last recorded completion |

## Verification
A toggle that holds the wrong value has two visible effects. It changes `look_odd` and moves `look_idx` and `look_addr` by one descriptor as soon as that endpoint direction is looked up, in the same cycle with no delay. It also shows up on `stat_odd` one cycle after the next completion on that direction. A numbering error for a given mode shows up on the very first lookup of an affected endpoint, because the lookup path holds no state. The bench therefore looks up neighbouring endpoint directions after each completion and each clear, so that a flip on the wrong bit cannot go unnoticed.

// File: rtl/ppbd_pkg.sv
package ppbd_pkg;

  typedef enum logic [1:0] {
    PP_NONE     = 2'b00,
    PP_EP0_OUT  = 2'b01,
    PP_ALL      = 2'b10,
    PP_NOT_EP0  = 2'b11
  } pp_mode_e;

  // True when this endpoint direction owns an even/odd descriptor pair.
  function automatic logic pair_active(pp_mode_e m, int unsigned ep, logic dir);
    case (m)
      PP_EP0_OUT: return (ep == 0) && (dir == 1'b0);
      PP_ALL:     return 1'b1;
      PP_NOT_EP0: return ep != 0;
      default:    return 1'b0;
    endcase
  endfunction

  // Descriptor number inside the table for one endpoint direction.
  function automatic int unsigned bd_slot(pp_mode_e m, int unsigned ep, logic dir, logic odd);
    int unsigned d;
    int unsigned o;
    d = dir ? 1 : 0;
    o = odd ? 1 : 0;
    case (m)
      PP_NONE:    return ep * 2 + d;
      PP_EP0_OUT: return (ep == 0 && d == 0) ? o : ep * 2 + d + 1;
      PP_ALL:     return ep * 4 + d * 2 + o;
      default:    return (ep == 0) ? d : ep * 4 + d * 2 + o - 2;
    endcase
  endfunction

  // Number of descriptors the table holds in a mode.
  function automatic int unsigned bd_count(pp_mode_e m, int unsigned n_ep);
    case (m)
      PP_NONE:    return 2 * n_ep;
      PP_EP0_OUT: return 2 * n_ep + 1;
      PP_ALL:     return 4 * n_ep;
      default:    return 4 * n_ep - 2;
    endcase
  endfunction

endpackage

// File: rtl/ppbd_ptr_bank.sv
module ppbd_ptr_bank
  import ppbd_pkg::*;
#(
  parameter int unsigned N_EP = 16,
  localparam int unsigned EP_W = $clog2(N_EP),
  localparam int unsigned SLOTS = 2 * N_EP,
  localparam int unsigned SLOT_W = EP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pp_mode_e         mode,
  input  logic             enable,
  input  logic             clr,
  input  logic             done,
  input  logic [EP_W-1:0]  done_ep,
  input  logic             done_dir,
  output logic [SLOTS-1:0] ptr_q,
  output logic             done_odd
);

  logic [SLOT_W-1:0] done_slot;
  logic              done_paired;
  logic              clr_evt;
  logic              tgl_evt;
  logic [SLOTS-1:0]  hit;

  assign done_slot   = {done_ep, done_dir};
  assign done_paired = pair_active(mode, int'(done_ep), done_dir);
  assign clr_evt     = !enable || clr;
  assign tgl_evt     = done && enable && !clr && done_paired;
  assign done_odd    = done_paired && ptr_q[done_slot];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic bit_q;
    assign hit[g] = tgl_evt && (done_slot == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bit_q <= 1'b0;
      else if (clr_evt) bit_q <= 1'b0;
      else if (hit[g])  bit_q <= ~bit_q;
    end
    assign ptr_q[g] = bit_q;
  end

  // R10: a clear (or disable) leaves every toggle Even on the next cycle
  a_r10_clear_all_even: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> ptr_q == '0);

  // R7: outside a clear, at most one toggle changes per cycle
  a_r7_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_evt) |-> $countones(ptr_q ^ $past(ptr_q)) <= 1);

  // R7: an accepted completion on a pair changes the toggle set
  a_r7_pair_moves: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_evt |=> ptr_q != $past(ptr_q));

  // R8: a completion on a single descriptor leaves the toggles alone
  a_r8_single_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable && !clr && !done_paired) |=> $stable(ptr_q));

endmodule

// File: rtl/ppbd_status.sv
module ppbd_status #(
  parameter int unsigned N_EP = 16,
  localparam int unsigned EP_W = $clog2(N_EP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            done,
  input  logic [EP_W-1:0] done_ep,
  input  logic            done_dir,
  input  logic            done_odd,
  output logic            stat_valid,
  output logic [EP_W-1:0] stat_ep,
  output logic            stat_dir,
  output logic            stat_odd
);

  logic take;
  assign take = done && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_ep    <= '0;
      stat_dir   <= 1'b0;
      stat_odd   <= 1'b0;
    end else if (take) begin
      stat_valid <= 1'b1;
      stat_ep    <= done_ep;
      stat_dir   <= done_dir;
      stat_odd   <= done_odd;
    end
  end

  // R9: accepted completion is recorded on the next cycle
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> stat_valid && stat_ep == $past(done_ep) && stat_dir == $past(done_dir)
             && stat_odd == $past(done_odd));

  // R1: while disabled the status does not move
  a_r1_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable({stat_valid, stat_ep, stat_dir, stat_odd}));

endmodule

// File: rtl/ppbd_lookup.sv
module ppbd_lookup
  import ppbd_pkg::*;
#(
  parameter int unsigned N_EP = 16,
  parameter int unsigned TABLE_BASE = 'h400,
  parameter int unsigned BD_BYTES = 4,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned EP_W = $clog2(N_EP),
  localparam int unsigned LOOK_EP_W = EP_W + 1,
  localparam int unsigned SLOTS = 2 * N_EP,
  localparam int unsigned SLOT_W = EP_W + 1,
  localparam int unsigned BD_W = $clog2(4 * N_EP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pp_mode_e             mode,
  input  logic [LOOK_EP_W-1:0] look_ep,
  input  logic                 look_dir,
  input  logic [SLOTS-1:0]     ptr_q,
  output logic [BD_W-1:0]      look_idx,
  output logic [ADDR_W-1:0]    look_addr,
  output logic                 look_odd,
  output logic                 look_invalid
);

  logic              in_range;
  logic              sel_paired;
  logic [SLOT_W-1:0] sel_slot;
  logic              sel_odd;
  int unsigned       slot_num;

  assign in_range   = look_ep < LOOK_EP_W'(N_EP);
  assign sel_slot   = {look_ep[EP_W-1:0], look_dir};
  assign sel_paired = pair_active(mode, int'(look_ep), look_dir);
  assign sel_odd    = sel_paired && ptr_q[sel_slot];
  assign slot_num   = bd_slot(mode, int'(look_ep), look_dir, sel_odd);

  always_comb begin
    look_invalid = !in_range;
    look_idx     = '0;
    look_addr    = '0;
    look_odd     = 1'b0;
    if (in_range) begin
      look_idx  = BD_W'(slot_num);
      look_addr = ADDR_W'(TABLE_BASE + slot_num * BD_BYTES);
      look_odd  = sel_odd;
    end
  end

  // R11: an out-of-range lookup yields zeros
  a_r11_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    look_invalid |-> (look_idx == '0 && look_addr == '0 && !look_odd));

  // R2: a valid index always lies inside the table of the current mode
  a_r2_idx_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    !look_invalid |-> int'(look_idx) < int'(bd_count(mode, N_EP)));

  // R6: a valid address is descriptor aligned and above the table base
  a_r6_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    !look_invalid |-> (look_addr[1:0] == 2'b00 && int'(look_addr) >= int'(TABLE_BASE)));

  // R8: single descriptors never resolve to the odd half
  a_r8_single_even: assert property (@(posedge clk) disable iff (!rst_n)
    (!look_invalid && !sel_paired) |-> !look_odd);

endmodule

// File: rtl/ppbd_indexer.sv
module ppbd_indexer
  import ppbd_pkg::*;
#(
  parameter int unsigned N_EP = 16,
  parameter int unsigned TABLE_BASE = 'h400,
  parameter int unsigned BD_BYTES = 4,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned EP_W = $clog2(N_EP),
  localparam int unsigned LOOK_EP_W = EP_W + 1,
  localparam int unsigned SLOTS = 2 * N_EP,
  localparam int unsigned BD_W = $clog2(4 * N_EP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pp_mode,
  input  logic                 enable,
  input  logic                 ptr_clear,
  input  logic                 xfer_done,
  input  logic [EP_W-1:0]      xfer_ep,
  input  logic                 xfer_dir,
  input  logic [LOOK_EP_W-1:0] look_ep,
  input  logic                 look_dir,
  output logic [BD_W-1:0]      look_idx,
  output logic [ADDR_W-1:0]    look_addr,
  output logic                 look_odd,
  output logic                 look_invalid,
  output logic                 stat_valid,
  output logic [EP_W-1:0]      stat_ep,
  output logic                 stat_dir,
  output logic                 stat_odd
);

  pp_mode_e         mode;
  logic [SLOTS-1:0] ptr_q;
  logic             done_odd;

  assign mode = pp_mode_e'(pp_mode);

  ppbd_ptr_bank #(.N_EP(N_EP)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .enable   (enable),
    .clr      (ptr_clear),
    .done     (xfer_done),
    .done_ep  (xfer_ep),
    .done_dir (xfer_dir),
    .ptr_q    (ptr_q),
    .done_odd (done_odd)
  );

  ppbd_status #(.N_EP(N_EP)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .done       (xfer_done),
    .done_ep    (xfer_ep),
    .done_dir   (xfer_dir),
    .done_odd   (done_odd),
    .stat_valid (stat_valid),
    .stat_ep    (stat_ep),
    .stat_dir   (stat_dir),
    .stat_odd   (stat_odd)
  );

  ppbd_lookup #(
    .N_EP       (N_EP),
    .TABLE_BASE (TABLE_BASE),
    .BD_BYTES   (BD_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_look (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .look_ep      (look_ep),
    .look_dir     (look_dir),
    .ptr_q        (ptr_q),
    .look_idx     (look_idx),
    .look_addr    (look_addr),
    .look_odd     (look_odd),
    .look_invalid (look_invalid)
  );

endmodule

// File: tb/ppbd_indexer_bench.sv
`timescale 1ns/1ps
module ppbd_indexer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pp_mode = 2'b00;
  logic       enable = 1'b0;
  logic       ptr_clear = 1'b0;
  logic       xfer_done = 1'b0;
  logic [3:0] xfer_ep = '0;
  logic       xfer_dir = 1'b0;
  logic [4:0] look_ep = '0;
  logic       look_dir = 1'b0;
  logic [5:0] look_idx;
  logic [11:0] look_addr;
  logic       look_odd, look_invalid;
  logic       stat_valid, stat_dir, stat_odd;
  logic [3:0] stat_ep;

  always #2 clk = ~clk;

  ppbd_indexer u_ppbd_indexer (
    .clk(clk), .rst_n(rst_n), .pp_mode(pp_mode), .enable(enable),
    .ptr_clear(ptr_clear), .xfer_done(xfer_done), .xfer_ep(xfer_ep),
    .xfer_dir(xfer_dir), .look_ep(look_ep), .look_dir(look_dir),
    .look_idx(look_idx), .look_addr(look_addr), .look_odd(look_odd),
    .look_invalid(look_invalid), .stat_valid(stat_valid), .stat_ep(stat_ep),
    .stat_dir(stat_dir), .stat_odd(stat_odd)
  );

  typedef struct {
    string req;
    bit    is_stat;
    int    idx;
    int    addr;
    bit    odd;
    bit    inv;
    bit    sv;
    int    sep;
    bit    sdir;
    bit    sodd;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_tests = 0;
  int    n_fail = 0;

  // bench model of the toggles and status
  bit m_ptr[16][2];
  bit m_sv = 0;
  int m_sep = 0;
  bit m_sdir = 0;
  bit m_sodd = 0;

  function automatic bit m_paired(int m, int e, int d);
    return (m == 2) || (m == 3 && e != 0) || (m == 1 && e == 0 && d == 0);
  endfunction

  // walk the table in endpoint order, counting 1 or 2 entries each
  function automatic int m_index(int m, int e, int d);
    int base = 0;
    for (int ee = 0; ee < 16; ee++) begin
      for (int dd = 0; dd < 2; dd++) begin
        if (ee == e && dd == d)
          return base + (m_paired(m, ee, dd) ? int'(m_ptr[ee][dd]) : 0);
        base += m_paired(m, ee, dd) ? 2 : 1;
      end
    end
    return -1;
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      item_t it;
      @(chk_ev);
      while (q.size() > 0) begin
        it = q.pop_front();
        n_tests++;
        if (it.is_stat) begin
          if (stat_valid !== it.sv || int'(stat_ep) != it.sep ||
              stat_dir !== it.sdir || stat_odd !== it.sodd) begin
            n_fail++;
            $display("FAIL %s status: got v=%0b ep=%0d dir=%0b odd=%0b exp v=%0b ep=%0d dir=%0b odd=%0b",
                     it.req, stat_valid, stat_ep, stat_dir, stat_odd,
                     it.sv, it.sep, it.sdir, it.sodd);
          end
        end else begin
          if (int'(look_idx) != it.idx || int'(look_addr) != it.addr ||
              look_odd !== it.odd || look_invalid !== it.inv) begin
            n_fail++;
            $display("FAIL %s lookup: got idx=%0d addr=%0h odd=%0b inv=%0b exp idx=%0d addr=%0h odd=%0b inv=%0b",
                     it.req, look_idx, look_addr, look_odd, look_invalid,
                     it.idx, it.addr, it.odd, it.inv);
          end
        end
      end
    end
  end

  task automatic do_look(input int e, input int d, input string req);
    item_t it;
    int m;
    @(negedge clk);
    look_ep  = 5'(e);
    look_dir = d[0];
    #1;
    m = int'(pp_mode);
    it = '{req: req, is_stat: 0, idx: 0, addr: 0, odd: 0, inv: 0,
           sv: 0, sep: 0, sdir: 0, sodd: 0};
    if (e > 15) begin
      it.inv = 1;
    end else begin
      it.idx  = m_index(m, e, d);
      it.addr = 'h400 + 4 * it.idx;
      it.odd  = m_paired(m, e, d) ? m_ptr[e][d] : 1'b0;
    end
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic check_stat(input string req);
    item_t it;
    it = '{req: req, is_stat: 1, idx: 0, addr: 0, odd: 0, inv: 0,
           sv: m_sv, sep: m_sep, sdir: m_sdir, sodd: m_sodd};
    #1;
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic do_xfer(input int e, input int d, input bit clr, input string req);
    int m;
    @(negedge clk);
    xfer_done = 1'b1;
    xfer_ep   = 4'(e);
    xfer_dir  = d[0];
    ptr_clear = clr;
    m = int'(pp_mode);
    @(negedge clk);
    xfer_done = 1'b0;
    ptr_clear = 1'b0;
    if (enable) begin
      m_sv   = 1;
      m_sep  = e;
      m_sdir = d[0];
      m_sodd = m_paired(m, e, d) ? m_ptr[e][d] : 1'b0;
      if (m_paired(m, e, d)) m_ptr[e][d] = ~m_ptr[e][d];
    end
    if (clr || !enable) m_clear();
    check_stat(req);
  endtask

  task automatic m_clear();
    for (int e = 0; e < 16; e++) begin
      m_ptr[e][0] = 0;
      m_ptr[e][1] = 0;
    end
  endtask

  task automatic set_mode(input int m);
    @(negedge clk);
    pp_mode = 2'(m);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_stat("R1");
    set_mode(2);
    do_look(1, 1, "R1_R4");

    // R2 / R6: no pairs
    set_mode(0);
    do_look(0, 0, "R2");
    do_look(7, 1, "R2");
    do_look(15, 1, "R2_R6");

    // R3: EP0 OUT pair only
    set_mode(1);
    do_look(0, 0, "R3");
    do_look(0, 1, "R3");
    do_look(15, 1, "R3_R6");
    do_xfer(0, 0, 0, "R3_R9");
    do_look(0, 0, "R3_R7");
    do_look(0, 1, "R3");

    // R5: all but EP0
    set_mode(3);
    do_look(0, 0, "R5");
    do_look(0, 1, "R5");
    do_look(1, 0, "R5");
    do_look(15, 1, "R5");
    do_xfer(15, 1, 0, "R5_R9");
    do_look(15, 1, "R5_R7");
    do_xfer(0, 1, 0, "R8");
    do_look(0, 1, "R8");

    // R4 / R7 / R9: all pairs, per-direction independence
    set_mode(2);
    do_xfer(3, 1, 0, "R7_R9");
    do_look(3, 1, "R4_R7");
    do_look(3, 0, "R7");
    do_look(4, 1, "R7");
    do_xfer(3, 1, 0, "R9");
    do_look(3, 1, "R4_R7");
    do_xfer(9, 0, 0, "R9");
    do_look(9, 0, "R4_R6");

    // R8: single-buffered completion does not toggle
    set_mode(0);
    do_xfer(5, 0, 0, "R8");
    set_mode(2);
    do_look(5, 0, "R8");

    // R10: clear, then clear colliding with a completion
    do_xfer(6, 1, 0, "R7");
    do_xfer(2, 0, 0, "R7");
    @(negedge clk);
    ptr_clear = 1'b1;
    @(negedge clk);
    ptr_clear = 1'b0;
    m_clear();
    do_look(6, 1, "R10");
    do_look(2, 0, "R10");
    do_xfer(8, 0, 0, "R7");
    do_xfer(8, 0, 1, "R10");
    do_look(8, 0, "R10");

    // R1: disabled module ignores completions and holds toggles Even
    do_xfer(11, 1, 0, "R7");
    @(negedge clk);
    enable = 1'b0;
    m_clear();
    do_xfer(12, 0, 0, "R1");
    do_look(11, 1, "R1");
    @(negedge clk);
    enable = 1'b1;
    do_look(11, 1, "R1");

    // R11: out-of-range endpoints
    do_look(16, 0, "R11");
    do_look(31, 1, "R11");
    do_look(15, 0, "R11");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule